// File: doc/BRIEF.md
# Read/Write Request Arbiter

This block merges two request streams, reads and writes, onto one downstream request port. Reads come straight from their valid/ready input. Writes first pass through a write request queue, which is `DEPTH` entries deep (32 by default). The queue pushes back on the write source once its occupancy reaches a programmable watermark. A single output register holds the request that was granted. It stays there until the downstream side takes it, so a grant is never withdrawn or replaced while it waits.

A 2-bit policy input selects the arbitration rule while the block runs:
- Reads win.
- Writes win.
- The two sides alternate.

An enable input gates the block. While it is low, requests from both sources are accepted and thrown away, and responses coming back from downstream are suppressed. A synchronous soft reset clears the queue, the output register and the alternation state. A busy output shows that requests are still held inside the block.

Top module: `rw_arbiter`

## Requirements
- R1: With `mode` = 2'b10, when a read is pending and the output register is free or being emptied, the read is granted ahead of any queued write.
- R2: With `mode` = 2'b01, no read is granted while the write queue holds at least one entry.
- R3: With `mode` = 2'b00 or 2'b11, when both sides are pending the side that did not receive the previous grant wins. A side that requests alone is granted in the same cycle (`rd_ready` high with the output register free).
- R4: While `out_valid` is high and `out_ready` is low, `out_is_wr`, `out_addr` and `out_data` hold their values, and `out_valid` stays high.
- R5: With `enable` low, `rd_ready` and `wr_ready` are both high and the accepted requests are dropped. Nothing is stored, so `out_valid` and `busy` remain low.
- R6: With `enable` low, `up_rsp_valid` is low. With `enable` high, `up_rsp_valid`, `up_rsp_wr` and `up_rsp_data` follow the `dn_rsp_*` inputs in the same cycle.
- R7: With `enable` high, `wr_ready` is low whenever write queue occupancy is greater than or equal to `watermark`. With the output held, `watermark` = 0 admits no write, and `watermark` = N > 0 admits N+1 writes (N in the queue, 1 in the output register).
- R8: `busy` is high while the queue or the output register holds a request, and low once both are empty.
- R9: After `rst_n` or a cycle with `soft_rst` high:
  - `out_valid` and `busy` are low.
  - The queue is empty.
  - The alternation state is set so that the first two-sided contention is won by the read.
- R10: Writes leave in the order they were accepted, each with its own address and data.
- R11: `out_is_wr` is 1 for a write and 0 for a read. A read carries its `rd_addr` and zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | 1 = normal operation, 0 = drop requests and responses |
| mode | input | 2 | 10 read first, 01 write first, 00/11 alternate |
| watermark | input | $clog2(DEPTH) | Queue occupancy at which writes are back-pressured |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted |
| rd_addr | input | AW | Read address |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| out_valid | output | 1 | Granted request valid |
| out_ready | input | 1 | Downstream accepts the granted request |
| out_is_wr | output | 1 | 1 = write, 0 = read |
| out_addr | output | AW | Granted address |
| out_data | output | DW | Granted write data (0 for reads) |
| dn_rsp_valid | input | 1 | Response from downstream valid |
| dn_rsp_wr | input | 1 | Response is a write commit |
| dn_rsp_data | input | DW | Response data |
| up_rsp_valid | output | 1 | Response forwarded upstream |
| up_rsp_wr | output | 1 | Forwarded write-commit flag |
| up_rsp_data | output | DW | Forwarded response data |
| busy | output | 1 | Requests held inside the block |

## Verification
The watermark is swept through every value from 0 to 31. In each case the output is stalled and writes are driven continuously; the number admitted must be the watermark plus one, or zero for a watermark of 0. The stream is then drained and the writes must come out intact and in order, which separates an off-by-one watermark compare from a broken queue.

For each of the four policy codes, one write is preloaded into the output register, three more into the queue, and three reads are offered. The resulting grant order differs for each rule: reads all first, writes all first, or strict alternation. A held-output stall, a disabled pass, a lone requester and a contention right after soft reset cover hold, drop, immediate grant and alternation-state reset.

// File: rtl/rw_arbiter.sv
module rw_arbiter #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1,
  localparam int EW   = AW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          enable,
  input  logic [1:0]    mode,
  input  logic [PW-1:0] watermark,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_is_wr,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  input  logic          dn_rsp_valid,
  input  logic          dn_rsp_wr,
  input  logic [DW-1:0] dn_rsp_data,
  output logic          up_rsp_valid,
  output logic          up_rsp_wr,
  output logic [DW-1:0] up_rsp_data,
  output logic          busy
);
  localparam logic [1:0] READ_FIRST  = 2'b10;
  localparam logic [1:0] WRITE_FIRST = 2'b01;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          last_wr;
  logic          pick_wr;

  wire q_ne      = cnt != '0;
  wire q_full    = (cnt >= CW'(watermark)) || (cnt == CW'(DEPTH));
  wire push      = enable && wr_valid && !q_full;
  wire rd_req    = enable && rd_valid;
  wire slot_free = !out_valid || out_ready;
  wire grant     = slot_free && (rd_req || q_ne);
  wire take_wr   = grant && pick_wr;
  wire take_rd   = grant && !pick_wr;
  wire [EW-1:0] head = mem[rp];

  always_comb begin
    case (mode)
      READ_FIRST:  pick_wr = !rd_req;
      WRITE_FIRST: pick_wr = q_ne;
      default:     pick_wr = q_ne && (!rd_req || !last_wr);
    endcase
  end

  assign wr_ready = enable ? !q_full : 1'b1;
  assign rd_ready = enable ? take_rd : 1'b1;
  assign busy     = out_valid || q_ne;

  assign up_rsp_valid = dn_rsp_valid && enable;
  assign up_rsp_wr    = dn_rsp_wr;
  assign up_rsp_data  = dn_rsp_data;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {wr_addr, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (soft_rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (take_wr) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(take_wr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_is_wr <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
      last_wr   <= 1'b1;
    end else if (soft_rst) begin
      out_valid <= 1'b0;
      out_is_wr <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
      last_wr   <= 1'b1;
    end else if (grant) begin
      out_valid <= 1'b1;
      out_is_wr <= pick_wr;
      out_addr  <= take_wr ? head[EW-1:DW] : rd_addr;
      out_data  <= take_wr ? head[DW-1:0] : '0;
      last_wr   <= pick_wr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rw_arbiter_chk.sv
module rw_arbiter_chk #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int PW = 5,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          enable,
  input logic [1:0]    mode,
  input logic [PW-1:0] watermark,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          wr_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_is_wr,
  input logic [AW-1:0] out_addr,
  input logic [DW-1:0] out_data,
  input logic          up_rsp_valid,
  input logic          busy,
  input logic [CW-1:0] cnt
);
  a_r1_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    enable && mode == 2'b10 && rd_valid && (!out_valid || out_ready) |-> rd_ready);

  a_r2_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    enable && mode == 2'b01 && cnt != '0 |-> !rd_ready);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !soft_rst |=>
      out_valid && $stable(out_is_wr) && $stable(out_addr) && $stable(out_data));

  a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> rd_ready && wr_ready);

  a_r6_rsp_block: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !up_rsp_valid);

  a_r7_watermark: assert property (@(posedge clk) disable iff (!rst_n)
    enable && cnt >= CW'(watermark) |-> !wr_ready);

  a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
    enable && rd_valid && rd_ready && !soft_rst |=> busy);

  a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !out_valid && cnt == '0);
endmodule

bind rw_arbiter rw_arbiter_chk #(.AW(AW), .DW(DW), .PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable), .mode(mode),
  .watermark(watermark), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .wr_ready(wr_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_is_wr(out_is_wr), .out_addr(out_addr), .out_data(out_data),
  .up_rsp_valid(up_rsp_valid), .busy(busy), .cnt(cnt)
);

// File: tb/tb_rw_arbiter.sv
module tb_rw_arbiter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, soft_rst = 1'b0, enable = 1'b1;
  logic [1:0] mode = 2'b00;
  logic [4:0] watermark = 5'd31;
  logic rd_valid = 1'b0, wr_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] rd_addr = '0, wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic rd_ready, wr_ready, out_valid, out_is_wr, busy;
  logic [7:0] out_addr;
  logic [15:0] out_data;
  logic dn_rsp_valid = 1'b0, dn_rsp_wr = 1'b0;
  logic [15:0] dn_rsp_data = '0;
  logic up_rsp_valid, up_rsp_wr;
  logic [15:0] up_rsp_data;

  rw_arbiter dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable), .mode(mode),
    .watermark(watermark), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_wr(out_is_wr),
    .out_addr(out_addr), .out_data(out_data), .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp_wr(dn_rsp_wr), .dn_rsp_data(dn_rsp_data), .up_rsp_valid(up_rsp_valid),
    .up_rsp_wr(up_rsp_wr), .up_rsp_data(up_rsp_data), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_soft_reset();
    @(negedge clk);
    soft_rst = 1'b1; rd_valid = 1'b0; wr_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    soft_rst = 1'b0;
  endtask

  // expected kind of the i-th granted request (1 = write) in the policy test
  function automatic bit exp_wr(int m, int i);
    if (i == 0) return 1'b1;
    if (m == 2) return i > 3;
    if (m == 1) return i <= 3;
    return (i % 2) == 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int acc, got, errs, racc, rseen, wseen, okcnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: reset state
    chk("R9 out_valid after reset", out_valid, 0);
    chk("R9 busy after reset", busy, 0);
    chk("R9 wr_ready after reset", wr_ready, 1);

    // R7/R8/R10: watermark sweep, then drain
    for (int wm = 0; wm < 32; wm++) begin
      do_soft_reset();
      watermark = 5'(wm); mode = 2'b00; enable = 1'b1; out_ready = 1'b0;
      acc = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 8'(16 + acc); wr_data = 16'(40960 + acc);
        #1;
        if (wr_ready) acc++;
      end
      @(negedge clk); wr_valid = 1'b0;
      chk($sformatf("R7 admitted writes wm=%0d", wm), acc, (wm == 0) ? 0 : wm + 1);
      chk($sformatf("R8 busy while holding wm=%0d", wm), busy, (wm != 0) ? 1 : 0);
      got = 0; errs = 0;
      for (int c = 0; c < 45; c++) begin
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        if (out_valid) begin
          if (!out_is_wr || out_addr != 8'(16 + got) || out_data != 16'(40960 + got)) errs++;
          got++;
        end
      end
      chk($sformatf("R10 drained count wm=%0d", wm), got, acc);
      chk($sformatf("R10 order/content errors wm=%0d", wm), errs, 0);
      chk($sformatf("R8 busy after drain wm=%0d", wm), busy, 0);
    end

    // R1/R2/R3/R11: policy per mode code
    for (int m = 0; m < 4; m++) begin
      do_soft_reset();
      mode = 2'(m); watermark = 5'd31; enable = 1'b1; out_ready = 1'b0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 8'(16 + k); wr_data = 16'(40960 + k);
      end
      @(negedge clk); wr_valid = 1'b0;
      @(negedge clk);
      racc = 0; got = 0; rseen = 0; wseen = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        rd_valid = (racc < 3); rd_addr = 8'(128 + racc); out_ready = 1'b1;
        #1;
        if (out_valid && got < 7) begin
          chk($sformatf("%s grant %0d kind mode=%0d", (m == 2) ? "R1" : (m == 1) ? "R2" : "R3", got, m),
              out_is_wr, exp_wr(m, got));
          if (out_is_wr) begin
            chk("R11 write addr", out_addr, 16 + wseen);
            wseen++;
          end else begin
            chk("R11 read addr/data", {out_addr, out_data}, {8'(128 + rseen), 16'h0});
            rseen++;
          end
          got++;
        end
        if (rd_valid && rd_ready) racc++;
      end
      chk($sformatf("R3 total grants mode=%0d", m), got, 7);
      rd_valid = 1'b0; out_ready = 1'b0;
    end

    // R3: a lone read is granted at once
    do_soft_reset();
    mode = 2'b00; out_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = 8'h33;
    #1;
    chk("R3 lone read granted at once", rd_ready, 1);
    @(negedge clk); rd_valid = 1'b0;
    @(negedge clk); out_ready = 1'b0;

    // R4: held grant
    do_soft_reset();
    mode = 2'b00; out_ready = 1'b0;
    @(negedge clk); rd_valid = 1'b1; rd_addr = 8'h55;
    @(negedge clk); rd_addr = 8'h66;
    okcnt = 0;
    repeat (5) begin
      @(negedge clk); #1;
      if (!rd_ready && out_valid && out_addr == 8'h55 && !out_is_wr) okcnt++;
    end
    chk("R4 grant held for 5 stalled cycles", okcnt, 5);
    chk("R11 held read flagged as read", out_is_wr, 0);

    // R9: soft reset mid-traffic, then first contention goes to the read
    do_soft_reset();
    #1;
    chk("R9 out_valid after soft reset", out_valid, 0);
    chk("R9 busy after soft reset", busy, 0);
    mode = 2'b00; out_ready = 1'b1;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 8'h20; wr_data = 16'hBEEF;
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b1; rd_addr = 8'h44;
    #1;
    chk("R9 first contention after reset won by read", rd_ready, 1);
    @(negedge clk); rd_valid = 1'b0;
    repeat (3) @(negedge clk);
    out_ready = 1'b0;

    // R5: disabled, requests dropped
    do_soft_reset();
    enable = 1'b0; okcnt = 0;
    repeat (5) begin
      @(negedge clk);
      rd_valid = 1'b1; wr_valid = 1'b1;
      #1;
      if (rd_ready && wr_ready) okcnt++;
    end
    @(negedge clk); rd_valid = 1'b0; wr_valid = 1'b0; enable = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R5 ready while disabled", okcnt, 5);
    chk("R5 nothing stored (out_valid)", out_valid, 0);
    chk("R5 nothing stored (busy)", busy, 0);

    // R6: response gating
    @(negedge clk);
    dn_rsp_valid = 1'b1; dn_rsp_wr = 1'b1; dn_rsp_data = 16'h1234; enable = 1'b0;
    #1;
    chk("R6 response blocked when disabled", up_rsp_valid, 0);
    enable = 1'b1;
    #1;
    chk("R6 response passed when enabled", {up_rsp_valid, up_rsp_wr, up_rsp_data}, {2'b11, 16'h1234});
    dn_rsp_valid = 1'b0;

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule